// File: doc/BRIEF.md
# Language Card Bank Switch Controller

This block holds the soft-switch state of a 16 KB RAM overlay that sits over the ROM at the top of a 64 KB address space. It watches the processor bus. Whenever a new access lands in a small window of control addresses, it updates three registered outputs, which the memory map decoder uses:

- **Read select:** whether reads in the overlay area return RAM or ROM.
- **Write lock:** whether writes to the overlay RAM are blocked.
- **Bank select:** which of two 4 KB RAM banks appears at 0xD000–0xDFFF.

The decoder decides between base and auxiliary RAM from its own zero-page selector. This block only supplies the three switch states.

The RAM-versus-ROM read choice does not come from a set/clear pair of addresses. It comes from comparing the two lowest address bits of the access. Write permission is harder to get than to lose. Two back-to-back qualifying reads unlock the RAM. Any other kind of access to the window locks it again.

An access is counted once, in the clock cycle in which the valid strobe rises. A strobe held high through wait states therefore acts as a single access.

Top module: `lcsw_ctrl`

## Requirements
- R1: After reset, `ram_read_en` is 0 (ROM read), `ram_write_lock` is 1 (writes blocked) and `bank1_sel` is 0 (second bank mapped).
- R2: On an access to the control window, `ram_read_en` becomes 1 when address bit 0 equals address bit 1, and 0 when the two bits differ. This holds for reads and writes alike.
- R3: On an access to the control window, `bank1_sel` takes the value of address bit 3. A value of 1 maps the first bank and 0 maps the second bank.
- R4: `ram_write_lock` goes to 0 on the second of two consecutive window accesses that are both reads (`bus_wr`=0) with address bit 0 = 1. It stays 0 on further such reads.
- R5: A window access that is a write, or that has address bit 0 = 0, sets `ram_write_lock` to 1 and restarts the count of qualifying reads.
- R6: Accesses outside 0xC080–0xC08F change no output. They also leave the count of qualifying reads unchanged.
- R7: An access is recognised only in the cycle where `bus_valid` rises. A strobe held high for several cycles counts as one access.
- R8: Outputs update on the clock edge that samples the access and hold their value in every cycle without a new access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Bus address |
| bus_valid | input | 1 | Bus access strobe; its rising cycle marks an access |
| bus_wr | input | 1 | 1 for a write access, 0 for a read |
| ram_read_en | output | 1 | 1: overlay reads come from RAM; 0: from ROM |
| ram_write_lock | output | 1 | 1: overlay RAM writes are blocked |
| bank1_sel | output | 1 | 1: first 4 KB bank at 0xD000; 0: second bank |

## Verification
The bench builds the block with its default parameters: a 16-bit address, the window based at 0xC080 spanning 16 addresses, and an unlock count of two reads. With these values, the full set of bit-0/bit-1 combinations and both bank codes can be reached from a few addresses. The bench also covers several ways an unlock sequence can be broken: by a write, by a bit-0-clear access, and by a held strobe. It places out-of-window accesses between the two unlocking reads to show that they leave the count alone.

// File: rtl/lcsw_pkg.sv
package lcsw_pkg;

    // Registered switch state handed to the memory map decoder
    typedef struct packed {
        logic ram_rd;   // 1: RAM visible for reads in overlay area
        logic wr_lock;  // 1: overlay RAM writes blocked
        logic bank1;    // 1: first 4 KB bank at 0xD000
    } lcsw_state_t;

    localparam lcsw_state_t LCSW_RESET = '{ram_rd: 1'b0, wr_lock: 1'b1, bank1: 1'b0};

    // One decoded control-window access
    typedef struct packed {
        logic hit;      // new access inside the control window
        logic is_wr;    // write direction
        logic b0;       // address bit 0
        logic b1;       // address bit 1
        logic b3;       // address bit 3
    } lcsw_access_t;

    // RAM read is chosen when the two low address bits agree
    function automatic logic lcsw_rd_select(input logic b0, input logic b1);
        return b0 == b1;
    endfunction

    // A read with bit 0 set advances the unlock sequence
    function automatic logic lcsw_unlock_step(input lcsw_access_t a);
        return !a.is_wr && a.b0;
    endfunction

endpackage

// File: rtl/lcsw_access_decode.sv
module lcsw_access_decode
    import lcsw_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] CTRL_BASE = 16'hC080,
    parameter int SPAN_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_valid,
    input  logic              bus_wr,
    output lcsw_access_t      acc
);
    localparam logic [ADDR_W-1:0] SPAN_MASK = ADDR_W'((1 << SPAN_LOG2) - 1);

    logic valid_q;
    logic in_window;

    always_ff @(posedge clk) begin
        if (rst) valid_q <= 1'b0;
        else     valid_q <= bus_valid;
    end

    always_comb begin
        in_window = (((bus_addr ^ CTRL_BASE) & ~SPAN_MASK) == '0);
        acc.hit   = bus_valid && !valid_q && in_window;
        acc.is_wr = bus_wr;
        acc.b0    = bus_addr[0];
        acc.b1    = bus_addr[1];
        acc.b3    = bus_addr[3];
    end
endmodule

// File: rtl/lcsw_wlock_seq.sv
module lcsw_wlock_seq
    import lcsw_pkg::*;
#(
    parameter int UNLOCK_READS = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  lcsw_access_t acc,
    output logic         wr_lock
);
    localparam int CNT_W = (UNLOCK_READS > 1) ? $clog2(UNLOCK_READS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(UNLOCK_READS - 1);

    logic [CNT_W-1:0] seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_lock <= LCSW_RESET.wr_lock;
            seen    <= '0;
        end else if (acc.hit) begin
            if (lcsw_unlock_step(acc)) begin
                if (seen >= LAST) wr_lock <= 1'b0;
                else              seen    <= seen + 1'b1;
            end else begin
                wr_lock <= 1'b1;
                seen    <= '0;
            end
        end
    end
endmodule

// File: rtl/lcsw_mode_regs.sv
module lcsw_mode_regs
    import lcsw_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  lcsw_access_t acc,
    output logic         ram_rd,
    output logic         bank1
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ram_rd <= LCSW_RESET.ram_rd;
            bank1  <= LCSW_RESET.bank1;
        end else if (acc.hit) begin
            ram_rd <= lcsw_rd_select(acc.b0, acc.b1);
            bank1  <= acc.b3;
        end
    end
endmodule

// File: rtl/lcsw_ctrl.sv
module lcsw_ctrl
    import lcsw_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] CTRL_BASE = 16'hC080,
    parameter int SPAN_LOG2 = 4,
    parameter int UNLOCK_READS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_valid,
    input  logic              bus_wr,
    output logic              ram_read_en,
    output logic              ram_write_lock,
    output logic              bank1_sel
);
    lcsw_access_t acc;
    lcsw_state_t  st;

    lcsw_access_decode #(
        .ADDR_W(ADDR_W), .CTRL_BASE(CTRL_BASE), .SPAN_LOG2(SPAN_LOG2)
    ) u_dec (
        .clk(clk), .rst(rst), .bus_addr(bus_addr),
        .bus_valid(bus_valid), .bus_wr(bus_wr), .acc(acc)
    );

    lcsw_wlock_seq #(.UNLOCK_READS(UNLOCK_READS)) u_lock (
        .clk(clk), .rst(rst), .acc(acc), .wr_lock(st.wr_lock)
    );

    lcsw_mode_regs u_mode (
        .clk(clk), .rst(rst), .acc(acc), .ram_rd(st.ram_rd), .bank1(st.bank1)
    );

    assign ram_read_en    = st.ram_rd;
    assign ram_write_lock = st.wr_lock;
    assign bank1_sel      = st.bank1;
endmodule

// File: rtl/lcsw_ctrl_chk.sv
module lcsw_ctrl_chk #(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] CTRL_BASE = 16'hC080,
    parameter int SPAN_LOG2 = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_valid,
    input logic              bus_wr,
    input logic              ram_read_en,
    input logic              ram_write_lock,
    input logic              bank1_sel
);
    localparam logic [ADDR_W-1:0] WIN_MASK = ADDR_W'((1 << SPAN_LOG2) - 1);

    logic strobe_prev;
    logic new_hit;

    always_ff @(posedge clk) begin
        if (rst) strobe_prev <= 1'b0;
        else     strobe_prev <= bus_valid;
    end

    assign new_hit = bus_valid && !strobe_prev
                     && (((bus_addr ^ CTRL_BASE) & ~WIN_MASK) == '0);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!ram_read_en && ram_write_lock && !bank1_sel));

    // R2
    rd_select_chk: assert property (@(posedge clk) disable iff (rst)
        new_hit |=> (ram_read_en == $past(bus_addr[0] == bus_addr[1])));

    // R3
    bank_select_chk: assert property (@(posedge clk) disable iff (rst)
        new_hit |=> (bank1_sel == $past(bus_addr[3])));

    // R5
    write_locks_chk: assert property (@(posedge clk) disable iff (rst)
        (new_hit && (bus_wr || !bus_addr[0])) |=> ram_write_lock);

    // R4
    unlock_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ram_write_lock) |-> $past(new_hit && !bus_wr && bus_addr[0]));

    // R6 R7 R8
    idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !new_hit |=> $stable({ram_read_en, ram_write_lock, bank1_sel}));
endmodule

bind lcsw_ctrl lcsw_ctrl_chk #(
    .ADDR_W(ADDR_W), .CTRL_BASE(CTRL_BASE), .SPAN_LOG2(SPAN_LOG2)
) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_valid(bus_valid),
    .bus_wr(bus_wr), .ram_read_en(ram_read_en),
    .ram_write_lock(ram_write_lock), .bank1_sel(bank1_sel)
);

// File: tb/lcsw_ctrl_tb.sv
module lcsw_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = '0;
    logic        bus_valid = 1'b0;
    logic        bus_wr = 1'b0;
    logic        ram_read_en, ram_write_lock, bank1_sel;

    lcsw_ctrl u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_valid(bus_valid),
        .bus_wr(bus_wr), .ram_read_en(ram_read_en),
        .ram_write_lock(ram_write_lock), .bank1_sel(bank1_sel)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [2:0] exp;   // {read_en, write_lock, bank1}
        string      tag;
    } exp_item_t;

    exp_item_t sb[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference model built from the requirements
    logic m_rd = 1'b0, m_lock = 1'b1, m_b1 = 1'b0;
    int   m_cnt = 0;

    task automatic model_reset();
        m_rd = 1'b0; m_lock = 1'b1; m_b1 = 1'b0; m_cnt = 0;
    endtask

    task automatic model_access(input logic [15:0] a, input logic w);
        if (a >= 16'hC080 && a <= 16'hC08F) begin
            m_rd = (a[0] == a[1]);
            m_b1 = a[3];
            if (!w && a[0]) begin
                if (m_cnt >= 1) m_lock = 1'b0;
                else            m_cnt  = m_cnt + 1;
            end else begin
                m_lock = 1'b1;
                m_cnt  = 0;
            end
        end
    endtask

    task automatic push_exp(input string tag);
        exp_item_t it;
        it.exp = {m_rd, m_lock, m_b1};
        it.tag = tag;
        sb.push_back(it);
    endtask

    // Driver: one access, strobe held for 'hold' cycles
    task automatic access(input logic [15:0] a, input logic w, input int hold, input string tag);
        @(negedge clk);
        bus_addr  = a;
        bus_wr    = w;
        bus_valid = 1'b1;
        repeat (hold) @(negedge clk);
        bus_valid = 1'b0;
        model_access(a, w);
        push_exp(tag);
    endtask

    task automatic idle(input int n, input string tag);
        repeat (n) @(negedge clk);
        push_exp(tag);
    endtask

    // Monitor: compares outputs against queued expectations
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0) begin
                exp_item_t it;
                logic [2:0] act;
                it  = sb.pop_front();
                act = {ram_read_en, ram_write_lock, bank1_sel};
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s: actual {rd,lock,b1}=%b expected %b", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
        push_exp("R1 reset state");

        access(16'hC080, 1'b0, 1, "R2 R3 bits equal, bank2");
        access(16'hC081, 1'b0, 1, "R2 bits differ, first unlock read");
        access(16'hC083, 1'b0, 1, "R4 second read unlocks");
        access(16'hC08B, 1'b0, 1, "R3 R4 bank1 stays unlocked");
        access(16'hC08A, 1'b0, 1, "R5 bit0 clear relocks");
        access(16'hC089, 1'b1, 1, "R2 R5 write relocks");
        access(16'hC089, 1'b0, 1, "R5 count 1");
        access(16'hC089, 1'b1, 1, "R5 write restarts count");
        access(16'hC089, 1'b0, 1, "R5 count restarted, still locked");
        access(16'hC08F, 1'b0, 1, "R4 R2 unlock after restart");

        access(16'hC0F0, 1'b0, 1, "R6 above window ignored");
        access(16'hC07A, 1'b1, 1, "R6 below window ignored");
        access(16'hD080, 1'b1, 1, "R6 far address ignored");

        access(16'hC080, 1'b0, 1, "R5 relock");
        access(16'hC081, 1'b0, 1, "R4 first read");
        access(16'hC071, 1'b1, 1, "R6 outside keeps count");
        access(16'hC085, 1'b0, 1, "R6 R4 count survived");

        access(16'hC084, 1'b0, 1, "R5 relock bank2");
        access(16'hC08D, 1'b0, 3, "R7 held strobe counts once");
        access(16'hC08D, 1'b0, 1, "R7 R4 next read unlocks");
        access(16'hC082, 1'b1, 4, "R7 R2 held write");

        idle(5, "R8 stable while idle");

        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
        push_exp("R1 state after second reset");

        repeat (3) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule